// File: doc/BRIEF.md
# RAM-Backed Programmable Delay Line

This block holds a stream of samples back by a selectable number of accepted input strobes, from 0 to 63. The samples sit in an addressed memory array and never move between locations. A write pointer and a read pointer walk around a ring inside that array, and the ring's size sets the delay. An input cycle with the strobe low is a gap. During a gap both pointers hold still, so the delay counts accepted samples, not clock cycles.

The active ring spans the delay plus one entries. On a (re)start the read pointer sits at the ring's first entry and the write pointer sits at its last entry. Both pointers step forward by one on every accepted sample and wrap at the end of the ring. The array has a synchronous read port. Data leaving the array comes straight from that port's register, and a zero setting switches the output to a bypass register. When the delay selection changes, the pointers are reloaded and the output strobe stays low until the ring has been refilled.

Top module: `ram_delay_line`

## Requirements
- R1: While reset is high, and on the first clock after it, `out_vld` is 0. The delay setting sampled during reset becomes the active delay.
- R2: With an active delay of 0, an edge that accepts a sample raises `out_vld` and presents that same sample on `out_data` right after the edge.
- R3: With an active delay D from 1 to 63, the edge that accepts the n-th sample since the last (re)start (n counted from 0, n >= D) presents sample n-D on `out_data` with `out_vld` high.
- R4: After reset or a reload with active delay D, the first D accepted samples produce `out_vld` = 0.
- R5: An edge with `in_vld` low drives `out_vld` to 0 and leaves the pointers unmoved, so gaps do not shift the alignment of R3.
- R6: An edge where `dly_sel` differs from the active delay discards that cycle's input and drives `out_vld` to 0. It makes `dly_sel` the active delay and restarts the fill count of R4.
- R7: The largest delay, 63, is reached with the 64-entry array and obeys R3 and R4.
- R8: The read pointer never leaves the active ring [0, D], and the write pointer is always the ring entry just before the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample |
| dly_sel | input | 6 | Requested delay in accepted samples (0 to 63) |
| out_vld | output | 1 | Output sample strobe |
| out_data | output | 16 | Delayed sample, meaningful while `out_vld` is high |

## Verification
A change of `dly_sel` can land on the same edge as an asserted `in_vld`, and the reload then takes priority over storing that sample. The bench provokes this by switching the delay in the middle of a dense stream, both from a long delay to a short one and from zero to a nonzero setting. Its queue model drops the colliding sample and starts the refill from empty. The bench then checks that `out_vld` stays low for exactly the new depth and that the first sample out is the one accepted after the change. A gap arriving on an edge just as the ring completes its fill is covered by irregular strobe patterns.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

    parameter int unsigned DATA_W   = 16;
    parameter int unsigned MAX_TAPS = 63;

    localparam int unsigned DEPTH = MAX_TAPS + 1;
    localparam int unsigned TAP_W = $clog2(DEPTH);

    typedef logic [TAP_W-1:0]  tap_t;
    typedef logic [DATA_W-1:0] word_t;

    // Address pair into the ring held in the array
    typedef struct packed {
        tap_t wr;
        tap_t rd;
    } ptr_pair_t;

    // One output beat
    typedef struct packed {
        logic  vld;
        word_t data;
    } beat_t;

    // Advance within a ring whose last index is 'last'
    function automatic tap_t ring_next(tap_t p, tap_t last);
        return (p == last) ? '0 : tap_t'(p + 1'b1);
    endfunction

endpackage

// File: rtl/rdl_store.sv
module rdl_store
    import rdl_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  tap_t  waddr,
    input  word_t wdata,
    input  logic  re,
    input  tap_t  raddr,
    output word_t rdata
);

    word_t mem [DEPTH];

    // Synchronous array: one write port, one registered read port
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/rdl_seq.sv
module rdl_seq
    import rdl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_vld,
    input  tap_t      dly_sel,
    output ptr_pair_t ptr,
    output tap_t      cur_tap,
    output logic      accept,
    output logic      emit
);

    tap_t tap_q;
    tap_t fill_q;
    logic reload;

    assign reload  = (dly_sel != tap_q);
    assign accept  = in_vld && !reload;
    assign cur_tap = tap_q;

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            tap_q  <= dly_sel;
            ptr.rd <= '0;
            ptr.wr <= dly_sel;
            fill_q <= '0;
            emit   <= 1'b0;
        end else begin
            emit <= accept && (fill_q == tap_q);
            if (accept) begin
                ptr.rd <= ring_next(ptr.rd, tap_q);
                ptr.wr <= ring_next(ptr.wr, tap_q);
                if (fill_q != tap_q) begin
                    fill_q <= fill_q + 1'b1;
                end
            end
        end
    end

    // R8: read pointer confined to the active ring
    a_r8_rd_in_ring: assert property (@(posedge clk) disable iff (rst)
        ptr.rd <= tap_q);

    // R8: write pointer trails the read pointer by one ring entry
    a_r8_wr_behind_rd: assert property (@(posedge clk) disable iff (rst)
        ptr.wr == ((ptr.rd == '0) ? tap_q : tap_t'(ptr.rd - 1'b1)));

    // R5: a gap leaves both pointers where they were
    a_r5_gap_holds_ptrs: assert property (@(posedge clk) disable iff (rst)
        (!in_vld && !reload) |=> $stable(ptr));

    // R6: a setting change restarts the ring and blanks the output
    a_r6_reload_restarts: assert property (@(posedge clk) disable iff (rst)
        reload |=> (!emit && ptr.rd == '0));

endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line
    import rdl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [TAP_W-1:0]    dly_sel,
    output logic                out_vld,
    output logic [DATA_W-1:0]   out_data
);

    ptr_pair_t ptr;
    tap_t      cur_tap;
    logic      accept;
    logic      emit;
    word_t     ram_q;
    word_t     byp_q;
    beat_t     beat;

    rdl_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .dly_sel (dly_sel),
        .ptr     (ptr),
        .cur_tap (cur_tap),
        .accept  (accept),
        .emit    (emit)
    );

    rdl_store u_store (
        .clk   (clk),
        .we    (accept),
        .waddr (ptr.wr),
        .wdata (in_data),
        .re    (accept),
        .raddr (ptr.rd),
        .rdata (ram_q)
    );

    // Zero-delay path skips the array
    always_ff @(posedge clk) begin
        if (accept) begin
            byp_q <= in_data;
        end
    end

    always_comb begin
        beat.vld  = emit;
        beat.data = (cur_tap == '0) ? byp_q : ram_q;
    end

    assign out_vld  = beat.vld;
    assign out_data = beat.data;

    // R2: zero setting returns the sample accepted on the last edge
    a_r2_bypass_same: assert property (@(posedge clk) disable iff (rst)
        (out_vld && cur_tap == '0) |-> (out_data == $past(in_data)));

    // R5: no strobe in, no strobe out
    a_r5_gap_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    // R6: a changed setting blanks the next output
    a_r6_change_blanks: assert property (@(posedge clk) disable iff (rst)
        (dly_sel != cur_tap) |=> !out_vld);

endmodule

// File: tb/test_ram_delay_line.sv
`timescale 1ns/1ps
module test_ram_delay_line;
    import rdl_pkg::*;

    logic  clk = 1'b0;
    logic  rst;
    logic  in_vld;
    word_t in_data;
    tap_t  dly_sel;
    logic  out_vld;
    word_t out_data;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cur_d = 0;
    int    idx   = 0;
    bit    done  = 1'b0;
    word_t mq[$];

    always #2.5 clk = ~clk;

    ram_delay_line i_ram_delay_line (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .in_data  (in_data),
        .dly_sel  (dly_sel),
        .out_vld  (out_vld),
        .out_data (out_data)
    );

    function automatic word_t pat(int i);
        return word_t'(i * 40503 + 17);
    endfunction

    task automatic compare(string tag, logic ev, word_t ed);
        n_chk++;
        if (out_vld !== ev) begin
            n_bad++;
            $display("FAIL %s out_vld act=%0b exp=%0b", tag, out_vld, ev);
        end else if (ev) begin
            n_chk++;
            if (out_data !== ed) begin
                n_bad++;
                $display("FAIL %s out_data act=%h exp=%h", tag, out_data, ed);
            end
        end
    endtask

    // Drive one cycle, advance the queue model, compare after the edge
    task automatic step(string tag, logic v, int sel);
        logic  ev;
        word_t ed;
        word_t d;
        d  = pat(idx);
        idx++;
        ev = 1'b0;
        ed = '0;
        @(negedge clk);
        in_vld  = v;
        in_data = d;
        dly_sel = tap_t'(sel);
        if (sel != cur_d) begin
            cur_d = sel;
            mq.delete();
        end else if (v) begin
            mq.push_back(d);
            if (mq.size() > cur_d) begin
                ev = 1'b1;
                ed = mq.pop_front();
            end
        end
        @(posedge clk);
        #1;
        compare(tag, ev, ed);
    endtask

    task automatic run(string tag, int sel, int cnt, int gap_mod);
        for (int i = 0; i < cnt; i++) begin
            step(tag, (gap_mod == 0) || ((i % gap_mod) != 1), sel);
        end
    endtask

    initial begin
        rst     = 1'b1;
        in_vld  = 1'b0;
        in_data = '0;
        dly_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (out_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 out_vld act=%0b exp=0", out_vld);
        end
        rst   = 1'b0;
        cur_d = 0;
        mq.delete();

        step("R1", 1'b0, 0);              // first edge after reset
        run("R2", 0, 12, 0);               // zero delay, dense
        run("R2", 0, 10, 3);               // zero delay, gaps
        step("R6", 1'b1, 5);               // change collides with strobe
        run("R4", 5, 5, 0);                // fill phase
        run("R3", 5, 30, 4);               // steady state with gaps
        run("R5", 5, 20, 2);               // every other cycle idle
        step("R6", 1'b1, 1);
        run("R3", 1, 20, 5);
        step("R6", 1'b1, 2);
        run("R3", 2, 25, 3);
        step("R6", 1'b0, 63);
        run("R7", 63, 140, 9);             // max depth, wraps twice
        step("R6", 1'b1, 0);               // long to zero mid-stream
        run("R2", 0, 6, 0);
        step("R6", 1'b1, 7);               // zero to nonzero mid-stream
        run("R4", 7, 7, 0);
        run("R3", 7, 40, 6);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule